// File: doc/BRIEF.md
# LPC I/O Register Target

This block is a peripheral on the LPC nibble bus. It answers host I/O read and I/O write cycles whose 16-bit address falls in a small, aligned window of byte registers. It follows the host's framing. It takes the shared nibble lines only after the host's turnaround. It inserts a configurable number of short-wait SYNC codes, and then either reports ready or flags an error. On a read it returns the byte, and in every claimed cycle it gives the bus back through a final turnaround.

The bidirectional nibble bus is split into an input, an output and an output enable. The pad logic outside the block combines them, and pull-ups make a released bus read as all ones. All inputs are sampled on the rising clock edge. The outputs come straight from registered state, so the value the target drives during a clock slot depends only on the slots that came before it.

Top module: `lpc_io_target`

## Requirements
- R1: While `bus_rst_n` is low, `nib_oe` is low and every register in the window is cleared to 0x00. After reset, every implemented register reads back 0x00.
- R2: The START code is the `nib_in` value in the last clock where `bus_frame_n` is low. The host may hold `bus_frame_n` low for several clocks. The target proceeds only when that last value is 0000.
- R3: The nibble in the first clock after `bus_frame_n` rises selects the cycle type, with bit 0 treated as don't-care. Bits [3:1] = 000 is an I/O read and 001 is an I/O write. Any other value makes the target keep `nib_oe` low until the next START.
- R4: The address takes four clocks, most significant nibble first. The target claims the cycle only when address bits [15:2] equal `BASE_ADDR[15:2]`, and bits [1:0] select the register. On a miss, `nib_oe` stays low for the whole cycle.
- R5: On a write, the data byte follows the address over two clocks, low nibble first. The register takes the byte only in the clock where the target drives the ready SYNC.
- R6: During the two turnaround clocks that follow the address (read) or the data (write), `nib_oe` is low.
- R7: The target then drives SYNC 0101 for exactly `WAIT_STATES` clocks, followed by 0000 (ready) in one clock.
- R8: On a read that completes with ready, the target drives the register byte in the next two clocks, low nibble first.
- R9: The final turnaround is one clock of 1111 with `nib_oe` high, then one clock with `nib_oe` low. The target then idles with `nib_oe` low.
- R10: If the addressed offset has its `IMPL_MASK` bit clear, the target drives SYNC 1010 instead of ready. No data phase follows, a write is discarded, and the final turnaround comes next.
- R11: When `bus_frame_n` is sampled low in any state, `nib_oe` is low from the next clock and a new START is taken. A write aborted before its ready SYNC leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all sampling on the rising edge |
| bus_rst_n | input | 1 | Active-low bus reset, asynchronous assert |
| bus_frame_n | input | 1 | Active-low cycle framing strobe from the host |
| nib_in | input | 4 | Nibble bus value as seen at the pins |
| nib_out | output | 4 | Nibble driven by the target when enabled |
| nib_oe | output | 1 | Target output enable for the nibble bus |

## Verification
The hardest situation to reach from the ports is an abort that lands in the middle of the short-wait SYNC slots of a write. At that point the data byte has been collected but not yet committed. The bench starts such a write and pulls `bus_frame_n` low in a chosen wait slot. That same slot serves as the START of a read of the same register, so the release of the bus and the unchanged old value are both seen through the normal read path. A second abort lands exactly on the ready slot of a read, and the unimplemented offset is swept with both directions to reach the error SYNC path.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_WDATA,
        ST_TAR1,
        ST_SYNC,
        ST_RDATA,
        ST_TAR2,
        ST_SKIP
    } tgt_state_e;

    localparam logic [3:0] NIB_START_TARGET = 4'h0;
    localparam logic [2:0] CT_IO_RD_HI      = 3'b000;
    localparam logic [2:0] CT_IO_WR_HI      = 3'b001;
    localparam logic [3:0] SYNC_READY       = 4'h0;
    localparam logic [3:0] SYNC_SHORT       = 4'h5;
    localparam logic [3:0] SYNC_ERROR       = 4'hA;
    localparam logic [3:0] NIB_RELEASE      = 4'hF;

endpackage

// File: rtl/lpc_tgt_regfile.sv
module lpc_tgt_regfile #(
    parameter int                   NUM_REGS  = 4,
    parameter int                   DW        = 8,
    parameter logic [NUM_REGS-1:0]  IMPL_MASK = {NUM_REGS{1'b1}},
    localparam int                  IW        = $clog2(NUM_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic          rd_impl
);

    logic [NUM_REGS-1:0][DW-1:0] regs_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (IMPL_MASK[g]) begin : g_impl
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs_q[g] <= '0;
                end else if (wr_en && (wr_idx == IW'(g))) begin
                    regs_q[g] <= wr_data;
                end
            end
        end else begin : g_hole
            assign regs_q[g] = '0;
        end
    end

    assign rd_data = regs_q[rd_idx];
    assign rd_impl = IMPL_MASK[rd_idx];

endmodule

// File: rtl/lpc_tgt_match.sv
module lpc_tgt_match #(
    parameter int              AW        = 16,
    parameter logic [AW-1:0]   BASE_ADDR = '0,
    parameter int              NUM_REGS  = 4,
    localparam int             IW        = $clog2(NUM_REGS)
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);

    assign hit = (addr[AW-1:IW] == BASE_ADDR[AW-1:IW]);

endmodule

// File: rtl/lpc_tgt_drive.sv
module lpc_tgt_drive
    import lpc_tgt_pkg::*;
#(
    parameter int CW          = 2,
    parameter int WAIT_STATES = 2
) (
    input  tgt_state_e    st,
    input  logic [CW-1:0] cnt,
    input  logic          impl,
    input  logic [7:0]    rdata,
    output logic [3:0]    nib,
    output logic          oe
);

    localparam logic [CW-1:0] WAIT_C = CW'(WAIT_STATES);

    always_comb begin
        nib = 4'h0;
        oe  = 1'b0;
        case (st)
            ST_SYNC: begin
                oe = 1'b1;
                if (cnt != WAIT_C) begin
                    nib = SYNC_SHORT;
                end else if (impl) begin
                    nib = SYNC_READY;
                end else begin
                    nib = SYNC_ERROR;
                end
            end
            ST_RDATA: begin
                oe  = 1'b1;
                nib = cnt[0] ? rdata[7:4] : rdata[3:0];
            end
            ST_TAR2: begin
                if (!cnt[0]) begin
                    oe  = 1'b1;
                    nib = NIB_RELEASE;
                end
            end
            default: begin
                oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lpc_io_target.sv
module lpc_io_target
    import lpc_tgt_pkg::*;
#(
    parameter logic [15:0]         BASE_ADDR   = 16'h0060,
    parameter int                  NUM_REGS    = 4,
    parameter int                  WAIT_STATES = 2,
    parameter logic [NUM_REGS-1:0] IMPL_MASK   = {NUM_REGS{1'b1}} >> 1
) (
    input  logic       clk,
    input  logic       bus_rst_n,
    input  logic       bus_frame_n,
    input  logic [3:0] nib_in,
    output logic [3:0] nib_out,
    output logic       nib_oe
);

    localparam int AW = 16;
    localparam int DW = 8;
    localparam int IW = $clog2(NUM_REGS);
    localparam int CW = (WAIT_STATES > 3) ? 3 : 2;
    localparam logic [CW-1:0] WAIT_C    = CW'(WAIT_STATES);
    localparam logic [CW-1:0] ADDR_LAST = CW'(AW / 4 - 1);

    typedef struct packed {
        tgt_state_e    st;
        logic [CW-1:0] cnt;
        logic          is_wr;
        logic [3:0]    start;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } ctx_t;

    localparam ctx_t CTX_RST = '{st: ST_IDLE, cnt: '0, is_wr: 1'b0,
                                 start: NIB_RELEASE, addr: '0, wdata: '0};

    ctx_t          ctx_q, ctx_d;
    logic [AW-1:0] addr_next;
    logic          hit_next;
    logic          wr_fire;
    logic [DW-1:0] rd_data;
    logic          rd_impl;
    tgt_state_e    state_now;

    assign addr_next = {ctx_q.addr[AW-5:0], nib_in};
    assign state_now = ctx_q.st;

    lpc_tgt_match #(
        .AW        (AW),
        .BASE_ADDR (BASE_ADDR),
        .NUM_REGS  (NUM_REGS)
    ) u_match (
        .addr (addr_next),
        .hit  (hit_next)
    );

    lpc_tgt_regfile #(
        .NUM_REGS  (NUM_REGS),
        .DW        (DW),
        .IMPL_MASK (IMPL_MASK)
    ) u_regs (
        .clk     (clk),
        .rst_n   (bus_rst_n),
        .wr_en   (wr_fire),
        .wr_idx  (ctx_q.addr[IW-1:0]),
        .wr_data (ctx_q.wdata),
        .rd_idx  (ctx_q.addr[IW-1:0]),
        .rd_data (rd_data),
        .rd_impl (rd_impl)
    );

    lpc_tgt_drive #(
        .CW          (CW),
        .WAIT_STATES (WAIT_STATES)
    ) u_drive (
        .st    (ctx_q.st),
        .cnt   (ctx_q.cnt),
        .impl  (rd_impl),
        .rdata (rd_data),
        .nib   (nib_out),
        .oe    (nib_oe)
    );

    always_comb begin
        ctx_d   = ctx_q;
        wr_fire = 1'b0;
        if (!bus_frame_n) begin
            // framing strobe low: (re)start, last nibble wins
            ctx_d.st    = ST_START;
            ctx_d.start = nib_in;
            ctx_d.cnt   = '0;
        end else begin
            case (ctx_q.st)
                ST_START: begin
                    ctx_d.cnt = '0;
                    if (ctx_q.start != NIB_START_TARGET) begin
                        ctx_d.st = ST_SKIP;
                    end else if (nib_in[3:1] == CT_IO_RD_HI) begin
                        ctx_d.st    = ST_ADDR;
                        ctx_d.is_wr = 1'b0;
                    end else if (nib_in[3:1] == CT_IO_WR_HI) begin
                        ctx_d.st    = ST_ADDR;
                        ctx_d.is_wr = 1'b1;
                    end else begin
                        ctx_d.st = ST_SKIP;
                    end
                end
                ST_ADDR: begin
                    ctx_d.addr = addr_next;
                    if (ctx_q.cnt == ADDR_LAST) begin
                        ctx_d.cnt = '0;
                        if (!hit_next) begin
                            ctx_d.st = ST_SKIP;
                        end else if (ctx_q.is_wr) begin
                            ctx_d.st = ST_WDATA;
                        end else begin
                            ctx_d.st = ST_TAR1;
                        end
                    end else begin
                        ctx_d.cnt = ctx_q.cnt + 1'b1;
                    end
                end
                ST_WDATA: begin
                    if (!ctx_q.cnt[0]) begin
                        ctx_d.wdata[3:0] = nib_in;
                        ctx_d.cnt        = ctx_q.cnt + 1'b1;
                    end else begin
                        ctx_d.wdata[7:4] = nib_in;
                        ctx_d.cnt        = '0;
                        ctx_d.st         = ST_TAR1;
                    end
                end
                ST_TAR1: begin
                    if (!ctx_q.cnt[0]) begin
                        ctx_d.cnt = ctx_q.cnt + 1'b1;
                    end else begin
                        ctx_d.cnt = '0;
                        ctx_d.st  = ST_SYNC;
                    end
                end
                ST_SYNC: begin
                    if (ctx_q.cnt != WAIT_C) begin
                        ctx_d.cnt = ctx_q.cnt + 1'b1;
                    end else begin
                        ctx_d.cnt = '0;
                        if (!rd_impl) begin
                            ctx_d.st = ST_TAR2;
                        end else if (ctx_q.is_wr) begin
                            wr_fire  = 1'b1;
                            ctx_d.st = ST_TAR2;
                        end else begin
                            ctx_d.st = ST_RDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (!ctx_q.cnt[0]) begin
                        ctx_d.cnt = ctx_q.cnt + 1'b1;
                    end else begin
                        ctx_d.cnt = '0;
                        ctx_d.st  = ST_TAR2;
                    end
                end
                ST_TAR2: begin
                    if (!ctx_q.cnt[0]) begin
                        ctx_d.cnt = ctx_q.cnt + 1'b1;
                    end else begin
                        ctx_d.cnt = '0;
                        ctx_d.st  = ST_IDLE;
                    end
                end
                default: begin
                    ctx_d.st = ctx_q.st;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge bus_rst_n) begin
        if (!bus_rst_n) begin
            ctx_q <= CTX_RST;
        end else begin
            ctx_q <= ctx_d;
        end
    end

endmodule

// File: rtl/lpc_io_target_chk.sv
module lpc_io_target_chk
    import lpc_tgt_pkg::*;
#(
    parameter int WAIT_STATES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_frame_n,
    input logic [3:0] nib_out,
    input logic       nib_oe,
    input tgt_state_e st
);

    logic [3:0] wait_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_run_q <= '0;
        end else if (nib_oe && (nib_out == SYNC_SHORT) && (st == ST_SYNC)) begin
            wait_run_q <= wait_run_q + 1'b1;
        end else begin
            wait_run_q <= '0;
        end
    end

    AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_frame_n |=> !nib_oe); // R11

    AST_SYNC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_oe && st == ST_SYNC) |->
            (nib_out == SYNC_SHORT || nib_out == SYNC_READY || nib_out == SYNC_ERROR)); // R7

    AST_RELEASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nib_oe) |-> ($past(nib_out) == NIB_RELEASE || !$past(bus_frame_n))); // R9

    AST_TAKE_AFTER_TAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nib_oe) |-> ($past(st) == ST_TAR1)); // R6

    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        wait_run_q <= 4'(WAIT_STATES)); // R7

endmodule

bind lpc_io_target lpc_io_target_chk #(
    .WAIT_STATES (WAIT_STATES)
) u_chk (
    .clk         (clk),
    .rst_n       (bus_rst_n),
    .bus_frame_n (bus_frame_n),
    .nib_out     (nib_out),
    .nib_oe      (nib_oe),
    .st          (state_now)
);

// File: tb/sim_lpc_io_target.sv
module sim_lpc_io_target;

    localparam int          CLK_PERIOD = 10;
    localparam int          WAITS      = 3;
    localparam logic [15:0] BASE       = 16'h02E8;
    localparam logic [3:0]  IMPL       = 4'b0111;

    logic       clk     = 1'b0;
    logic       rst_n   = 1'b0;
    logic       frame_n = 1'b1;
    logic [3:0] nin     = 4'hF;
    logic [3:0] nout;
    logic       noe;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    logic [7:0] mdl [4];

    always #(CLK_PERIOD / 2) clk = ~clk;

    lpc_io_target #(
        .BASE_ADDR   (BASE),
        .NUM_REGS    (4),
        .WAIT_STATES (WAITS),
        .IMPL_MASK   (IMPL)
    ) u0 (
        .clk         (clk),
        .bus_rst_n   (rst_n),
        .bus_frame_n (frame_n),
        .nib_in      (nin),
        .nib_out     (nout),
        .nib_oe      (noe)
    );

    task automatic check_out(input logic e_oe, input logic [3:0] e_nib, input string req);
        n_chk++;
        if (noe !== e_oe || (e_oe && nout !== e_nib)) begin
            n_fail++;
            $display("FAIL %s: oe=%b nib=%h expected oe=%b nib=%h at %0t",
                     req, noe, nout, e_oe, e_nib, $time);
        end
    endtask

    // one bus clock: check what the target drives in this slot, then drive host side
    task automatic slot(input logic fr, input logic [3:0] nib,
                        input logic e_oe, input logic [3:0] e_nib, input string req);
        @(negedge clk);
        check_out(e_oe, e_nib, req);
        frame_n = fr;
        nin     = nib;
    endtask

    task automatic run_io(input logic [3:0] start, input logic [3:0] ct,
                          input logic [15:0] addr, input logic [7:0] wd,
                          input int nlead, input logic [3:0] lead,
                          input bit have_start, input int abort_at, input string req);
        bit         wr;
        bit         act;
        bit         err;
        int         off;
        logic [3:0] e;
        wr  = ct[1];
        act = (start == 4'h0) && (ct[3:2] == 2'b00) && (addr[15:2] == BASE[15:2]);
        off = int'(addr[1:0]);
        err = !IMPL[off];
        if (!have_start) begin
            for (int i = 0; i < nlead; i++) slot(1'b0, lead, 1'b0, 4'h0, "R2");
            slot(1'b0, start, 1'b0, 4'h0, req);
        end
        slot(1'b1, ct, 1'b0, 4'h0, req);
        for (int i = 3; i >= 0; i--) slot(1'b1, addr[i*4 +: 4], 1'b0, 4'h0, req);
        if (wr) begin
            slot(1'b1, wd[3:0], 1'b0, 4'h0, req);
            slot(1'b1, wd[7:4], 1'b0, 4'h0, req);
        end
        slot(1'b1, 4'hF, 1'b0, 4'h0, "R6");
        slot(1'b1, 4'hF, 1'b0, 4'h0, "R6");
        for (int i = 0; i <= WAITS; i++) begin
            e = (i < WAITS) ? 4'h5 : (err ? 4'hA : 4'h0);
            if (i == abort_at) begin
                slot(1'b0, 4'h0, act, e, "R11");
                return;
            end
            slot(1'b1, 4'hF, act, e, (i < WAITS) ? "R7" : (err ? "R10" : "R7"));
        end
        if (!wr && !err) begin
            slot(1'b1, 4'hF, act, mdl[off][3:0], "R8");
            slot(1'b1, 4'hF, act, mdl[off][7:4], "R8");
        end
        slot(1'b1, 4'hF, act, 4'hF, "R9");
        slot(1'b1, 4'hF, 1'b0, 4'h0, "R9");
        if (act && wr && !err) mdl[off] = wd;
    endtask

    task automatic rd(input logic [15:0] a, input string req);
        run_io(4'h0, 4'h0, a, 8'h00, 0, 4'hF, 1'b0, -1, req);
    endtask

    task automatic wrt(input logic [15:0] a, input logic [7:0] d, input string req);
        run_io(4'h0, 4'h2, a, d, 0, 4'hF, 1'b0, -1, req);
    endtask

    task automatic read_all(input string req);
        for (int k = 0; k < 4; k++) rd(BASE + 16'(k), req);
    endtask

    initial begin
        logic [15:0] miss [4];
        for (int k = 0; k < 4; k++) mdl[k] = 8'h00;
        repeat (3) @(negedge clk);
        check_out(1'b0, 4'h0, "R1");
        rst_n = 1'b1;
        slot(1'b1, 4'hF, 1'b0, 4'h0, "R1");
        read_all("R1");

        // full data sweep on offset 0 with read-back
        for (int d = 0; d < 256; d++) begin
            wrt(BASE, 8'(d), "R5");
            rd(BASE, "R8");
        end

        // every offset, both directions, including the hole at offset 3
        for (int k = 0; k < 4; k++) wrt(BASE + 16'(k), 8'h5A ^ 8'(k * 8'h33), "R10");
        read_all("R10");

        // cycle-type bit 0 is don't-care
        run_io(4'h0, 4'h3, BASE + 16'd2, 8'hC3, 0, 4'hF, 1'b0, -1, "R3");
        run_io(4'h0, 4'h1, BASE + 16'd2, 8'h00, 0, 4'hF, 1'b0, -1, "R3");

        // unclaimed cycle types
        for (int k = 2; k < 8; k++) begin
            run_io(4'h0, 4'(k * 2), BASE, 8'hFF, 0, 4'hF, 1'b0, -1, "R3");
        end
        read_all("R3");

        // non-target START codes
        for (int s = 1; s < 16; s++) begin
            run_io(4'(s), 4'h2, BASE + 16'd1, 8'hEE, 0, 4'hF, 1'b0, -1, "R2");
            run_io(4'(s), 4'h0, BASE + 16'd1, 8'h00, 0, 4'hF, 1'b0, -1, "R2");
        end
        read_all("R2");

        // long framing: only the last nibble counts
        run_io(4'h0, 4'h2, BASE + 16'd1, 8'h96, 3, 4'hF, 1'b0, -1, "R2");
        run_io(4'hD, 4'h2, BASE + 16'd1, 8'h11, 2, 4'h0, 1'b0, -1, "R2");
        rd(BASE + 16'd1, "R2");

        // addresses outside the window
        miss[0] = BASE - 16'd1;
        miss[1] = BASE + 16'd4;
        miss[2] = BASE ^ 16'h8000;
        miss[3] = BASE ^ 16'h0100;
        for (int k = 0; k < 4; k++) begin
            wrt(miss[k], 8'h00, "R4");
            rd(miss[k], "R4");
        end
        read_all("R4");

        // abort a write during a wait slot; that slot starts a read of the same register
        run_io(4'h0, 4'h2, BASE + 16'd1, 8'h3E, 0, 4'hF, 1'b0, 1, "R11");
        run_io(4'h0, 4'h0, BASE + 16'd1, 8'h00, 0, 4'hF, 1'b1, -1, "R11");
        // abort a read on its ready slot, then read again
        run_io(4'h0, 4'h0, BASE + 16'd2, 8'h00, 0, 4'hF, 1'b0, WAITS, "R11");
        run_io(4'h0, 4'h0, BASE + 16'd2, 8'h00, 0, 4'hF, 1'b1, -1, "R11");

        // reset clears the register file
        wrt(BASE, 8'hA5, "R1");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_out(1'b0, 4'h0, "R1");
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) mdl[k] = 8'h00;
        read_all("R1");

        slot(1'b1, 4'hF, 1'b0, 4'h0, "R9");
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule